// File: doc/BRIEF.md
# Dual 16x16 Multiply-Accumulate Unit

This block is a two-stage pipelined multiply-accumulate engine. Its core is a signed 32x16 multiplier array. The same array can be set up in two other ways. It can split into two signed 16x16 multipliers whose products are summed in one operation. It can also be fed twice in a row to build a full 32x32 product. An accumulate operand arrives on a port of its own and is added to the product or to the product sum when accumulation is enabled.

Stage 1 holds the array result and stage 2 holds the accumulated result. A valid bit travels with each operation and ends as a one-cycle done strobe. The stage registers load only while an operation occupies them and keep their contents otherwise.

A small controller has two states. The first is `ST_IDLE`, where a new operation may be accepted. The second is `ST_HIGH_PASS`, the second array pass of a 32x32 multiply. There are two transitions. `ST_IDLE` moves to `ST_HIGH_PASS` when a 32x32 operation is accepted. `ST_HIGH_PASS` always returns to `ST_IDLE` after one cycle. An `in_valid` that arrives while the controller is in `ST_HIGH_PASS` is dropped.

Top module: `mac_dual16`

## Requirements
- R1: After reset, `done` is 0, `result` is 0 and `dual_ovf` is 0.
- R2: Mode code 2'b00 returns signed `op_a` times signed `op_b[15:0]` as a 64-bit value. `done` is high for one cycle, two clock edges after the edge that accepts the operation.
- R3: Mode code 2'b01 returns the 64-bit signed product `op_a * op_b`. It is built in two array passes: first with the low halfword of `op_b` taken as unsigned, then with the high halfword taken as signed and shifted left by 16. `done` rises three edges after acceptance and is low after the second edge.
- R4: Mode code 2'b10 returns `op_a[15:0]*op_b[15:0] + op_a[31:16]*op_b[31:16]`, with all halves taken as signed. The sum wraps to 32 bits and is sign-extended to 64 bits. `done` follows the same timing as R2.
- R5: Mode code 2'b11 swaps the halves of `op_b` before the multiply and returns `op_a[15:0]*op_b[31:16] + op_a[31:16]*op_b[15:0]`. It wraps and extends as in R4.
- R6: With `acc_en` = 1, `acc_in` is sign-extended and added. In modes 00 and 01 the add wraps at 64 bits. In the dual modes it is part of the 32-bit sum. With `acc_en` = 0, `acc_in` has no effect on `result`.
- R7: `dual_ovf` sets when a dual-mode sum, including the accumulate term, falls outside the signed 32-bit range. It rises on the same edge as that operation's `done` and stays set until reset.
- R8: An `in_valid` seen during the second pass of a 32x32 multiply is ignored. No extra `done` is produced and the 32x32 result is unaffected.
- R9: While `done` is low, `result` keeps its last value.
- R10: Single-pass operations (modes 00, 10, 11) can be accepted on every cycle. Each one produces its own `done` in order, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| mode | input | 2 | Operation code (00 32x16, 01 32x32, 10 dual, 11 dual crossed) |
| op_a | input | 32 | Multiplicand A |
| op_b | input | 32 | Multiplicand B |
| acc_in | input | 32 | Accumulate operand |
| acc_en | input | 1 | Add accumulate operand |
| result | output | 64 | Accumulated result |
| done | output | 1 | Result valid strobe |
| dual_ovf | output | 1 | Sticky dual-mode overflow |

## Verification
The bound checker watches the timing on every cycle. It checks the two-edge latency of single-pass operations and the three-edge latency of a 32x32 multiply. It checks that the high-pass state never lasts more than one cycle, that `result` holds whenever `done` is low, and that the overflow flag never clears once set. The arithmetic itself can only be shown by the bench's sweeps. These include the signed corner values, the dual sum that reaches 2^31, the crossed halves, and the accumulate operand being ignored when disabled. The same holds for the dropped strobe during the high pass and for back-to-back issue.

// File: rtl/mac_dual16_pkg.sv
package mac_dual16_pkg;
    typedef enum logic [1:0] {
        MODE_MUL_WS = 2'b00,
        MODE_MUL_WW = 2'b01,
        MODE_DUAL   = 2'b10,
        MODE_DUAL_X = 2'b11
    } mac_mode_e;

    typedef enum logic {
        ST_IDLE,
        ST_HIGH_PASS
    } ctrl_state_e;
endpackage

// File: rtl/mac_array.sv
module mac_array
    import mac_dual16_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] a,
    input  logic [2*HALF_W-1:0] b,
    input  mac_mode_e           mode,
    input  logic                pass_hi,
    output logic [4*HALF_W-1:0] prod
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int RES_W  = 4 * HALF_W;
    localparam int WIDE_W = FULL_W + HALF_W + 2;

    logic [HALF_W:0]     mb;
    logic [WIDE_W-1:0]   wide;
    logic [HALF_W-1:0]   bx_lo, bx_hi;
    logic [FULL_W-1:0]   p0, p1;
    logic [FULL_W:0]     dsum;

    // operand B selection for the 32x16 array
    always_comb begin
        if (mode == MODE_MUL_WW && !pass_hi)
            mb = {1'b0, b[HALF_W-1:0]};
        else if (mode == MODE_MUL_WW)
            mb = {b[FULL_W-1], b[FULL_W-1:HALF_W]};
        else
            mb = {b[HALF_W-1], b[HALF_W-1:0]};
    end

    assign wide = $signed({{(WIDE_W-FULL_W){a[FULL_W-1]}}, a})
                * $signed({{(WIDE_W-HALF_W-1){mb[HALF_W]}}, mb});

    // split configuration: two 16x16 signed products
    assign bx_lo = (mode == MODE_DUAL_X) ? b[FULL_W-1:HALF_W] : b[HALF_W-1:0];
    assign bx_hi = (mode == MODE_DUAL_X) ? b[HALF_W-1:0] : b[FULL_W-1:HALF_W];
    assign p0 = $signed({{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]})
              * $signed({{HALF_W{bx_lo[HALF_W-1]}}, bx_lo});
    assign p1 = $signed({{HALF_W{a[FULL_W-1]}}, a[FULL_W-1:HALF_W]})
              * $signed({{HALF_W{bx_hi[HALF_W-1]}}, bx_hi});
    assign dsum = {p0[FULL_W-1], p0} + {p1[FULL_W-1], p1};

    always_comb begin
        if (mode == MODE_DUAL || mode == MODE_DUAL_X)
            prod = {{(RES_W-FULL_W-1){dsum[FULL_W]}}, dsum};
        else
            prod = {{(RES_W-WIDE_W){wide[WIDE_W-1]}}, wide};
    end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
    import mac_dual16_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  mac_mode_e           mode,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic [2*HALF_W-1:0] acc_in,
    input  logic                acc_en,
    input  logic [4*HALF_W-1:0] arr_prod,
    output logic [2*HALF_W-1:0] arr_a,
    output logic [2*HALF_W-1:0] arr_b,
    output mac_mode_e           arr_mode,
    output logic                arr_pass_hi,
    output logic                s1_valid,
    output logic [4*HALF_W-1:0] s1_prod,
    output logic [2*HALF_W-1:0] s1_acc,
    output logic                s1_acc_en,
    output logic                s1_dual,
    output logic                busy_hi
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int RES_W  = 4 * HALF_W;

    ctrl_state_e       state_q, state_d;
    logic [FULL_W-1:0] a_q, b_q;
    logic [RES_W-1:0]  part_q;
    logic              accept, accept_wide;

    assign accept      = in_valid && (state_q == ST_IDLE);
    assign accept_wide = accept && (mode == MODE_MUL_WW);
    assign busy_hi     = (state_q == ST_HIGH_PASS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept_wide) state_d = ST_HIGH_PASS;
            ST_HIGH_PASS: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        arr_a       = op_a;
        arr_b       = op_b;
        arr_mode    = mode;
        arr_pass_hi = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIGH_PASS: begin
                arr_a       = a_q;
                arr_b       = b_q;
                arr_mode    = MODE_MUL_WW;
                arr_pass_hi = 1'b1;
            end
        endcase
    end

    // stage-1 registers: loaded only when an operation occupies them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_prod   <= '0;
            s1_acc    <= '0;
            s1_acc_en <= 1'b0;
            s1_dual   <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
            part_q    <= '0;
        end else begin
            s1_valid <= (accept && !accept_wide) || busy_hi;
            if (accept) begin
                s1_acc    <= acc_in;
                s1_acc_en <= acc_en;
                s1_dual   <= (mode == MODE_DUAL) || (mode == MODE_DUAL_X);
            end
            if (accept_wide) begin
                a_q    <= op_a;
                b_q    <= op_b;
                part_q <= arr_prod;
            end else if (accept) begin
                s1_prod <= arr_prod;
            end
            if (busy_hi)
                s1_prod <= part_q + (arr_prod << HALF_W);
        end
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s1_valid,
    input  logic [4*HALF_W-1:0] s1_prod,
    input  logic [2*HALF_W-1:0] s1_acc,
    input  logic                s1_acc_en,
    input  logic                s1_dual,
    output logic [4*HALF_W-1:0] result,
    output logic                done,
    output logic                dual_ovf
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int RES_W  = 4 * HALF_W;

    logic [RES_W-1:0]  acc_x, wsum, nxt;
    logic [FULL_W+1:0] dsum;
    logic              dov;

    assign acc_x = s1_acc_en ? {{(RES_W-FULL_W){s1_acc[FULL_W-1]}}, s1_acc} : '0;
    assign wsum  = s1_prod + acc_x;
    assign dsum  = {s1_prod[FULL_W], s1_prod[FULL_W:0]}
                 + {{2{acc_x[FULL_W-1]}}, acc_x[FULL_W-1:0]};
    assign dov   = (dsum[FULL_W+1] != dsum[FULL_W]) || (dsum[FULL_W] != dsum[FULL_W-1]);
    assign nxt   = s1_dual ? {{(RES_W-FULL_W){dsum[FULL_W-1]}}, dsum[FULL_W-1:0]} : wsum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            done     <= 1'b0;
            dual_ovf <= 1'b0;
        end else begin
            done <= s1_valid;
            if (s1_valid) result <= nxt;
            if (s1_valid && s1_dual && dov) dual_ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/mac_dual16.sv
module mac_dual16
    import mac_dual16_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          mode,
    input  logic [2*HALF_W-1:0] op_a,
    input  logic [2*HALF_W-1:0] op_b,
    input  logic [2*HALF_W-1:0] acc_in,
    input  logic                acc_en,
    output logic [4*HALF_W-1:0] result,
    output logic                done,
    output logic                dual_ovf
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int RES_W  = 4 * HALF_W;

    logic [FULL_W-1:0] arr_a, arr_b, s1_acc;
    mac_mode_e         arr_mode;
    logic              arr_pass_hi, s1_valid, s1_acc_en, s1_dual, busy_hi;
    logic [RES_W-1:0]  arr_prod, s1_prod;

    mac_ctrl #(.HALF_W(HALF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mac_mode_e'(mode)),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in), .acc_en(acc_en),
        .arr_prod(arr_prod), .arr_a(arr_a), .arr_b(arr_b), .arr_mode(arr_mode),
        .arr_pass_hi(arr_pass_hi), .s1_valid(s1_valid), .s1_prod(s1_prod),
        .s1_acc(s1_acc), .s1_acc_en(s1_acc_en), .s1_dual(s1_dual), .busy_hi(busy_hi)
    );

    mac_array #(.HALF_W(HALF_W)) u_array (
        .a(arr_a), .b(arr_b), .mode(arr_mode), .pass_hi(arr_pass_hi), .prod(arr_prod)
    );

    mac_accum #(.HALF_W(HALF_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_prod(s1_prod),
        .s1_acc(s1_acc), .s1_acc_en(s1_acc_en), .s1_dual(s1_dual),
        .result(result), .done(done), .dual_ovf(dual_ovf)
    );
endmodule

// File: rtl/mac_dual16_chk.sv
module mac_dual16_chk #(
    parameter int RES_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       mode,
    input logic             busy_hi,
    input logic             done,
    input logic             dual_ovf,
    input logic [RES_W-1:0] result
);
    assert_single_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy_hi && mode != 2'b01) |-> ##2 done);

    assert_wide_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy_hi && mode == 2'b01) |-> ##1 busy_hi ##1 !done ##1 done);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dual_ovf |=> dual_ovf);

    assert_high_pass_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hi |=> !busy_hi);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind mac_dual16 mac_dual16_chk #(.RES_W(4*HALF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .busy_hi(busy_hi),
    .done(done), .dual_ovf(dual_ovf), .result(result)
);

// File: tb/mac_dual16_test.sv
`timescale 1ns/1ps
module mac_dual16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
    logic        acc_en = 1'b0;
    logic [63:0] result;
    logic        done, dual_ovf;

    int checks = 0;
    int failures = 0;
    logic exp_ovf = 1'b0;

    always #4 clk = ~clk;

    mac_dual16 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in), .acc_en(acc_en),
        .result(result), .done(done), .dual_ovf(dual_ovf)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] acc, input logic en,
                                          input logic [1:0] md, output logic ov);
        longint sa  = longint'($signed(a));
        longint sb  = longint'($signed(b));
        longint sac = en ? longint'($signed(acc)) : 0;
        longint p0, p1, sum;
        logic [15:0] blo, bhi;
        ov = 1'b0;
        case (md)
            2'b00: return 64'(sa * longint'($signed(b[15:0])) + sac);
            2'b01: return 64'(sa * sb + sac);
            default: begin
                blo = (md == 2'b11) ? b[31:16] : b[15:0];
                bhi = (md == 2'b11) ? b[15:0] : b[31:16];
                p0  = longint'($signed(a[15:0])) * longint'($signed(blo));
                p1  = longint'($signed(a[31:16])) * longint'($signed(bhi));
                sum = p0 + p1 + sac;
                ov  = (sum > 64'sd2147483647) || (sum < -64'sd2147483648);
                return 64'(longint'($signed(sum[31:0])));
            end
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] md);
        case (md)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                          input logic en, input logic [1:0] md);
        logic [63:0] exp;
        logic ov;
        string rq;
        exp = model(a, b, acc, en, md, ov);
        rq = en ? {req_of(md), "/R6"} : {req_of(md), "/R6-off"};
        @(negedge clk);
        op_a = a; op_b = b; acc_in = acc; acc_en = en; mode = md; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        if (md == 2'b01) begin
            chk(done == 1'b0, "R3 done early", {63'd0, done}, 64'd0);
            @(negedge clk);
        end
        chk(done == 1'b1, {rq, " done"}, {63'd0, done}, 64'd1);
        chk(result == exp, {rq, " result"}, result, exp);
        if (md[1]) exp_ovf = exp_ovf | ov;
        chk(dual_ovf == exp_ovf, "R7 ovf", {63'd0, dual_ovf}, {63'd0, exp_ovf});
        @(negedge clk);
        chk(done == 1'b0 && result == exp, "R9 hold", result, exp);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] vals [8];
        logic [63:0] e0, e1, e2;
        logic ov;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h8000_8000;
        vals[6] = 32'h7FFF_8001; vals[7] = 32'h1234_ABCD;

        repeat (3) @(negedge clk);
        chk(done == 1'b0 && result == 64'd0 && dual_ovf == 1'b0, "R1 reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && result == 64'd0 && dual_ovf == 1'b0, "R1 after release", result, 64'd0);

        // sweep over corner operands, all modes, accumulate on and off
        for (int md = 0; md < 4; md++)
            for (int en = 0; en < 2; en++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        run_op(vals[i], vals[j], vals[i] ^ {vals[j][15:0], vals[j][31:16]} ^ 32'h5A5A_0F0F,
                               en[0], md[1:0]);

        // R1 again and R7 sticky behaviour from a clean start
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(dual_ovf == 1'b0 && result == 64'd0, "R1 re-reset", {63'd0, dual_ovf}, 64'd0);
        rst_n = 1'b1; exp_ovf = 1'b0;
        run_op(32'h0000_0003, 32'h0000_0004, 32'd0, 1'b0, 2'b10);
        run_op(32'h8000_8000, 32'h8000_8000, 32'd0, 1'b0, 2'b10);
        chk(dual_ovf == 1'b1, "R7 set", {63'd0, dual_ovf}, 64'd1);
        run_op(32'h0002_0002, 32'h0003_0003, 32'd7, 1'b1, 2'b11);
        chk(dual_ovf == 1'b1, "R7 stays", {63'd0, dual_ovf}, 64'd1);

        // R8: strobe during second pass is ignored
        e0 = model(32'hDEAD_BEEF, 32'h1357_9BDF, 32'h0000_0100, 1'b1, 2'b01, ov);
        @(negedge clk);
        op_a = 32'hDEAD_BEEF; op_b = 32'h1357_9BDF; acc_in = 32'h0000_0100; acc_en = 1'b1;
        mode = 2'b01; in_valid = 1'b1;
        @(negedge clk);
        op_a = 32'h0000_0005; op_b = 32'h0000_0007; acc_en = 1'b0; mode = 2'b00;
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b0, "R8 no early done", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk(done == 1'b1 && result == e0, "R8 wide result", result, e0);
        @(negedge clk);
        chk(done == 1'b0 && result == e0, "R8 no extra done", result, e0);

        // R10: three single-pass operations back to back
        e0 = model(32'h0001_0002, 32'h0003_0004, 32'd0, 1'b0, 2'b10, ov);
        e1 = model(32'hFFFF_FFF0, 32'h0000_0010, 32'd9, 1'b1, 2'b00, ov);
        e2 = model(32'h0005_FFFF, 32'h0002_0003, 32'd1, 1'b1, 2'b11, ov);
        @(negedge clk);
        op_a = 32'h0001_0002; op_b = 32'h0003_0004; acc_in = 32'd0; acc_en = 1'b0; mode = 2'b10; in_valid = 1'b1;
        @(negedge clk);
        op_a = 32'hFFFF_FFF0; op_b = 32'h0000_0010; acc_in = 32'd9; acc_en = 1'b1; mode = 2'b00;
        @(negedge clk);
        op_a = 32'h0005_FFFF; op_b = 32'h0002_0003; acc_in = 32'd1; acc_en = 1'b1; mode = 2'b11;
        chk(done == 1'b1 && result == e0, "R10 first", result, e0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(done == 1'b1 && result == e1, "R10 second", result, e1);
        @(negedge clk);
        chk(done == 1'b1 && result == e2, "R10 third", result, e2);
        @(negedge clk);
        chk(done == 1'b0, "R10 drained", {63'd0, done}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule